// File: doc/BRIEF.md
# Unified Data-Space Access Decoder

This block accepts one load/store request on a flat 16-bit data address space and routes it to one of four storage targets that share that space: the general-purpose register file, the standard I/O tier, the extended I/O tier and the on-chip SRAM. Each target is held inside the block as a simple behavioural byte array. The block drives a one-hot target select and the byte offset inside the chosen target. It also drives a ready signal that tells the requester when the access completes.

Short I/O-instruction accesses carry a 6-bit port number instead of a full address. The block places that port number on the data space at the base of the standard I/O tier. As a result, these accesses can only reach the standard I/O registers. Register and I/O targets complete in the cycle of the request. SRAM inserts a wait state. Addresses above the SRAM are flagged as out of range and have no effect.

The requester keeps its request and all request fields stable until it sees ready high. The access completes on the clock edge where request and ready are both high.

Top module: `dspace_decoder`

## Requirements
- R1: Data addresses 0x0000 to 0x001F select the register file: sel_o = 4'b0001 and offset_o = address.
- R2: Data addresses 0x0020 to 0x005F select the standard I/O tier: sel_o = 4'b0010 and offset_o = address - 0x20.
- R3: Data addresses 0x0060 to 0x00FF select the extended I/O tier: sel_o = 4'b0100 and offset_o = address - 0x60.
- R4: Data addresses 0x0100 to 0x02FF select the SRAM: sel_o = 4'b1000 and offset_o = address - 0x100.
- R5: When io_i is 1, addr_i is ignored and the effective address is 0x20 + port_i. Such an access therefore always selects the standard I/O tier and never the extended tier.
- R6: A register-file or I/O access has ready_o high in its first cycle. A write commits on that clock edge, and a read returns its byte on rdata_o in the same cycle.
- R7: An SRAM access holds ready_o low for exactly one cycle and raises it in the second cycle. The read data is valid in the second cycle, and a write commits on the edge that ends it.
- R8: An effective address of 0x0300 or above sets oor_o = 1 and sel_o = 0, and completes in one cycle. Its reads return 0x00, and its writes change no target (including SRAM byte 0x0100).
- R9: sel_o is one-hot during a request and all-zero without one. A write changes only the addressed byte of the selected target, and a later read of that address returns the written value.
- R10: After reset, and whenever req_i is low, ready_o = 1, sel_o = 0, oor_o = 0 and rdata_o = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| io_i | input | 1 | 1 = I/O-instruction access using port_i |
| addr_i | input | 16 | Load/store data address |
| port_i | input | 6 | I/O port number |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid when req_i and ready_o |
| ready_o | output | 1 | Access completes on this edge |
| sel_o | output | 4 | One-hot target: bit0 regs, bit1 std I/O, bit2 ext I/O, bit3 SRAM |
| offset_o | output | 9 | Byte offset inside the selected target |
| oor_o | output | 1 | Effective address beyond SRAM |

## Verification
The stall property assumes that a requester raising req_i on an SRAM address keeps the address, direction and I/O flag unchanged until ready_o rises. Without this, a ready SRAM cycle could follow a cycle that targeted some other region. The bench drives every request through one task. That task sets the fields on a falling edge and releases them only after the completing rising edge, so the hold rule is met on every access. The bench also never lets an I/O flag change mid-request.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
  // Target indices; the order fixes the sel_o bit positions.
  localparam int unsigned TGT_GPR  = 0;
  localparam int unsigned TGT_SIO  = 1;
  localparam int unsigned TGT_XIO  = 2;
  localparam int unsigned TGT_SRAM = 3;
  localparam int unsigned TGT_N    = 4;

  typedef logic [TGT_N-1:0] tgt_sel_t;
endpackage

// File: rtl/dspace_rst_sync.sv
// Asserts reset at once, releases it two clock edges later.
module dspace_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dspace_addr_map.sv
// Forms the effective address and decodes it into target, offset and range flag.
module dspace_addr_map
  import dspace_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned PW     = 6,
  parameter int unsigned OW     = 9,
  parameter int unsigned GPR_N  = 32,
  parameter int unsigned SIO_N  = 64,
  parameter int unsigned XIO_N  = 160,
  parameter int unsigned SRAM_N = 512
) (
  input  logic          io_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] port_i,
  output tgt_sel_t      hit_o,
  output logic [OW-1:0] offset_o,
  output logic          oor_o
);
  localparam int unsigned SIO_BASE  = GPR_N;
  localparam int unsigned XIO_BASE  = SIO_BASE + SIO_N;
  localparam int unsigned SRAM_BASE = XIO_BASE + XIO_N;
  localparam int unsigned SPACE_END = SRAM_BASE + SRAM_N;

  logic [AW-1:0] eff_addr;
  logic [AW-1:0] rel_addr;

  always_comb begin
    if (io_i) eff_addr = {{(AW-PW){1'b0}}, port_i} + AW'(SIO_BASE);
    else      eff_addr = addr_i;
  end

  always_comb begin
    hit_o    = '0;
    rel_addr = '0;
    oor_o    = 1'b0;
    if (eff_addr < AW'(SIO_BASE)) begin
      hit_o[TGT_GPR] = 1'b1;
      rel_addr       = eff_addr;
    end else if (eff_addr < AW'(XIO_BASE)) begin
      hit_o[TGT_SIO] = 1'b1;
      rel_addr       = eff_addr - AW'(SIO_BASE);
    end else if (eff_addr < AW'(SRAM_BASE)) begin
      hit_o[TGT_XIO] = 1'b1;
      rel_addr       = eff_addr - AW'(XIO_BASE);
    end else if (eff_addr < AW'(SPACE_END)) begin
      hit_o[TGT_SRAM] = 1'b1;
      rel_addr        = eff_addr - AW'(SRAM_BASE);
    end else begin
      oor_o = 1'b1;
    end
  end

  assign offset_o = rel_addr[OW-1:0];

  logic unused_rel;
  assign unused_rel = ^rel_addr[AW-1:OW];
endmodule

// File: rtl/dspace_wait_ctl.sv
// Counts wait states for slow targets and drives the ready handshake.
module dspace_wait_ctl #(
  parameter int unsigned SLOW_WAIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic slow_i,
  output logic ready_o
);
  localparam int unsigned CW = (SLOW_WAIT < 1) ? 1 : $clog2(SLOW_WAIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SLOW_WAIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          stall;

  always_comb begin
    stall  = req_i && slow_i && (cnt_q != LIMIT);
    cnt_d  = cnt_q;
    if (stall)       cnt_d = cnt_q + 1'b1;
    else             cnt_d = '0;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = !stall;
endmodule

// File: rtl/dspace_bank.sv
// Behavioural byte array: combinational read, write on the clock edge.
module dspace_bank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dspace_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned PW        = 6,
  parameter int unsigned GPR_N     = 32,
  parameter int unsigned SIO_N     = 64,
  parameter int unsigned XIO_N     = 160,
  parameter int unsigned SRAM_N    = 512,
  parameter int unsigned SRAM_WAIT = 1,
  localparam int unsigned OW       = $clog2(SRAM_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          io_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] port_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic [TGT_N-1:0] sel_o,
  output logic [OW-1:0] offset_o,
  output logic          oor_o
);
  localparam int unsigned TGT_DEPTH [TGT_N] = '{GPR_N, SIO_N, XIO_N, SRAM_N};

  logic          rst_sync_n;
  tgt_sel_t      hit;
  logic          oor_raw;
  logic [OW-1:0] offset;
  logic [DW-1:0] bank_rd [TGT_N];
  logic          bank_we [TGT_N];

  dspace_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dspace_addr_map #(
    .AW(AW), .PW(PW), .OW(OW),
    .GPR_N(GPR_N), .SIO_N(SIO_N), .XIO_N(XIO_N), .SRAM_N(SRAM_N)
  ) u_map (
    .io_i     (io_i),
    .addr_i   (addr_i),
    .port_i   (port_i),
    .hit_o    (hit),
    .offset_o (offset),
    .oor_o    (oor_raw)
  );

  dspace_wait_ctl #(.SLOW_WAIT(SRAM_WAIT)) u_wait (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_i   (req_i),
    .slow_i  (hit[TGT_SRAM]),
    .ready_o (ready_o)
  );

  for (genvar g = 0; g < TGT_N; g++) begin : g_bank
    localparam int unsigned BW = (TGT_DEPTH[g] < 2) ? 1 : $clog2(TGT_DEPTH[g]);

    assign bank_we[g] = req_i && we_i && ready_o && hit[g];

    dspace_bank #(.DEPTH(TGT_DEPTH[g]), .DW(DW)) u_bank (
      .clk     (clk),
      .we_i    (bank_we[g]),
      .idx_i   (offset[BW-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < TGT_N; t++) begin
      if (req_i && hit[t]) rdata_o = rdata_o | bank_rd[t];
    end
  end

  assign sel_o    = req_i ? hit : '0;
  assign oor_o    = req_i && oor_raw;
  assign offset_o = offset;
endmodule

// File: rtl/dspace_decoder_chk.sv
module dspace_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       io_i,
  input logic [7:0] rdata_o,
  input logic       ready_o,
  input logic [3:0] sel_o,
  input logic       oor_o
);
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && !oor_o |-> $onehot(sel_o));

  // R8
  oor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oor_o |-> (sel_o == 4'b0000) && (rdata_o == 8'h00) && ready_o);

  // R6
  fast_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && !sel_o[3] |-> ready_o);

  // R7
  sram_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && sel_o[3] && ready_o |-> $past(req_i && sel_o[3] && !ready_o));

  // R7
  sram_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && sel_o[3] && !ready_o |=> ready_o);

  // R5
  io_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && io_i |-> sel_o == 4'b0010);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> ready_o && (sel_o == 4'b0000) && !oor_o && (rdata_o == 8'h00));
endmodule

bind dspace_decoder dspace_decoder_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .io_i    (io_i),
  .rdata_o (rdata_o),
  .ready_o (ready_o),
  .sel_o   (sel_o),
  .oor_o   (oor_o)
);

// File: tb/sim_dspace_decoder.sv
`timescale 1ns/1ps
module sim_dspace_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic        io_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [5:0]  port_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ready_o;
  logic [3:0]  sel_o;
  logic [8:0]  offset_o;
  logic        oor_o;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dspace_decoder u0 (.*);

  // captured results of the last access
  logic [7:0] r_data;
  logic [3:0] r_sel;
  logic [8:0] r_off;
  logic       r_oor;
  int         r_waits;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic io, input logic [15:0] a,
                        input logic [5:0] p, input logic [7:0] d);
    bit done;
    @(negedge clk);
    req_i = 1'b1; we_i = we; io_i = io; addr_i = a; port_i = p; wdata_i = d;
    r_waits = 0;
    done = 0;
    while (!done) begin
      #2;
      if (ready_o) begin
        r_data = rdata_o; r_sel = sel_o; r_off = offset_o; r_oor = oor_o;
        done = 1;
      end else begin
        r_waits++;
        @(negedge clk);
      end
    end
    @(posedge clk);
    #1;
    req_i = 1'b0; we_i = 1'b0; io_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10", "ready idle", int'(ready_o), 1);
    check("R10", "sel idle", int'(sel_o), 0);
    check("R10", "oor idle", int'(oor_o), 0);
    check("R10", "rdata idle", int'(rdata_o), 0);
  endtask

  task automatic t_gpr();
    access(1, 0, 16'h0005, 0, 8'hA5);
    check("R1", "sel 0x05", int'(r_sel), 1);
    check("R6", "waits gpr write", r_waits, 0);
    access(1, 0, 16'h001F, 0, 8'h3C);
    access(0, 0, 16'h0005, 0, 0);
    check("R6", "gpr read data", int'(r_data), 'hA5);
    access(0, 0, 16'h001F, 0, 0);
    check("R1", "offset 0x1F", int'(r_off), 'h1F);
    check("R9", "gpr read 0x1F", int'(r_data), 'h3C);
  endtask

  task automatic t_sio();
    access(1, 0, 16'h0020, 0, 8'h11);
    check("R2", "sel 0x20", int'(r_sel), 2);
    check("R2", "offset 0x20", int'(r_off), 0);
    access(0, 0, 16'h005F, 0, 0);
    check("R2", "offset 0x5F", int'(r_off), 'h3F);
    check("R6", "sio waits", r_waits, 0);
  endtask

  task automatic t_xio();
    access(1, 0, 16'h0060, 0, 8'h22);
    check("R3", "sel 0x60", int'(r_sel), 4);
    check("R3", "offset 0x60", int'(r_off), 0);
    access(1, 0, 16'h00FF, 0, 8'h9E);
    check("R3", "offset 0xFF", int'(r_off), 'h9F);
    access(0, 0, 16'h00FF, 0, 0);
    check("R3", "xio read 0xFF", int'(r_data), 'h9E);
  endtask

  task automatic t_sram();
    access(1, 0, 16'h0100, 0, 8'h44);
    check("R4", "sel 0x100", int'(r_sel), 8);
    check("R4", "offset 0x100", int'(r_off), 0);
    check("R7", "sram write waits", r_waits, 1);
    access(1, 0, 16'h02FF, 0, 8'hC3);
    check("R4", "offset 0x2FF", int'(r_off), 'h1FF);
    access(0, 0, 16'h02FF, 0, 0);
    check("R7", "sram read waits", r_waits, 1);
    check("R7", "sram read 0x2FF", int'(r_data), 'hC3);
    access(0, 0, 16'h0100, 0, 0);
    check("R7", "sram read 0x100", int'(r_data), 'h44);
  endtask

  task automatic t_io();
    access(1, 1, 16'h0150, 6'h3F, 8'h77);
    check("R5", "io sel", int'(r_sel), 2);
    check("R5", "io offset", int'(r_off), 'h3F);
    access(0, 0, 16'h005F, 0, 0);
    check("R5", "io write lands at 0x5F", int'(r_data), 'h77);
    access(0, 1, 16'h0300, 6'h00, 0);
    check("R5", "io addr_i ignored oor", int'(r_oor), 0);
    check("R5", "io port 0 data", int'(r_data), 'h11);
    access(0, 0, 16'h0100, 0, 0);
    check("R5", "sram 0x100 untouched by io", int'(r_data), 'h44);
  endtask

  task automatic t_oor();
    access(1, 0, 16'h0300, 0, 8'h55);
    check("R8", "oor flag", int'(r_oor), 1);
    check("R8", "oor sel", int'(r_sel), 0);
    check("R8", "oor waits", r_waits, 0);
    access(0, 0, 16'h0300, 0, 0);
    check("R8", "oor read", int'(r_data), 0);
    access(0, 0, 16'h0100, 0, 0);
    check("R8", "sram 0x100 after oor write", int'(r_data), 'h44);
    access(0, 0, 16'hFFFF, 0, 0);
    check("R8", "oor 0xFFFF", int'(r_oor), 1);
  endtask

  task automatic t_isolation();
    access(0, 0, 16'h0000, 0, 0);
    r_data = r_data;
    access(1, 0, 16'h0000, 0, 8'h33);
    access(0, 0, 16'h0020, 0, 0);
    check("R9", "sio 0x20 kept", int'(r_data), 'h11);
    access(0, 0, 16'h0060, 0, 0);
    check("R9", "xio 0x60 kept", int'(r_data), 'h22);
    access(0, 0, 16'h0000, 0, 0);
    check("R9", "gpr 0x00 written", int'(r_data), 'h33);
    access(0, 0, 16'h0005, 0, 0);
    check("R9", "gpr 0x05 kept", int'(r_data), 'hA5);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_gpr();
    t_sio();
    t_xio();
    t_sram();
    t_io();
    t_oor();
    t_isolation();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule